// File: doc/BRIEF.md
# SPI Flash Page-Erase Command Front End

This block sits on the target side of a serial flash device. It takes SPI mode-0 traffic on a clock, a chip-select and a data-in pin, and it returns status on a data-out pin. All SPI pins are oversampled in the system clock domain. On each rising serial clock edge while chip select is low, one bit is shifted in, most significant bit first. Three commands are decoded: a write-enable (opcode 06h), a status read (opcode 05h) and a page erase (opcode DBh followed by a 24-bit address).

The block holds a write-enable latch and a busy (write-in-progress) flag. An accepted page erase raises `erase_req` with the page index taken from address bits 16:8, which gives 256-byte pages. The request stays high until the memory-array model answers on `erase_done`, so the array model owns the real erase time. A per-page protect vector is sampled when the erase is accepted. Any command with the wrong length, an erase without the latch set, an erase aimed at a protected page, and any write-enable or erase that arrives while busy are all dropped.

While busy, the write-enable latch clears after a parameterised number of cycles. At the latest it clears when the cycle ends.

Top module: `spi_erase_frontend`

## Requirements
- R1: After reset, `erase_req` and `spi_miso` are 0, and a status read returns 00h.
- R2: A write-enable (06h) sets the latch only if chip select rises after exactly 8 bits. A frame of 7 or 9 bits leaves the latch unchanged.
- R3: After the opcode 05h, the status byte is shifted out MSB first, with the value changing on falling serial clock edges. Bit 0 is write-in-progress, bit 1 is the write-enable latch and bits 7:2 are 0. The byte repeats for as long as clocking continues, and `spi_miso` is 0 during the opcode byte.
- R4: A page erase (DBh plus address) framed by exactly 32 bits raises `erase_req` with `erase_page` equal to address bits 16:8. Address bits 23:17 and 7:0 do not affect the page.
- R5: A page-erase frame of any length other than 32 bits starts no erase and leaves the latch set.
- R6: A page erase issued while the write-enable latch is clear starts no erase.
- R7: A page erase whose page has its `page_protect` bit set at acceptance starts no erase and leaves the latch set.
- R8: Write-in-progress reads 1 from acceptance until the cycle in which `erase_done` is seen. `erase_req` stays high over the same window.
- R9: The write-enable latch clears WEL_CLR_CYCLES cycles into the busy window, or at `erase_done` if that comes first.
- R10: A write-enable or page erase that arrives while busy is discarded, and `erase_page` holds its value until the running cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial status data to the host |
| page_protect | input | PAGES | Per-page protect bits, 1 = protected |
| erase_req | output | 1 | Erase request to the array, held until done |
| erase_page | output | PAGE_BITS | Index of the page to erase |
| erase_done | input | 1 | One-cycle completion pulse from the array |

## Verification
Each SPI pin passes through one synchronizer stage and one edge-detect stage. As a result, `erase_req` rises within two system clocks of chip select going high, and `spi_miso` settles within three system clocks of a falling serial clock edge. The bench holds each serial clock phase for six system clocks, so it reads `spi_miso` just before it raises the serial clock, as a mode-0 host would. It checks `erase_req` and the request count four clocks after it releases chip select. It checks latch and busy state only by status reads made after a command has had time to settle. The timing of the latch clear inside the busy window is checked cycle by cycle by a counter in the checker.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_PERASE = 8'hDB;
  localparam int         ST_WIP    = 0;
  localparam int         ST_WEL    = 1;
  localparam int         FRAME_PE_BYTES = 4;
  localparam int         SR_BITS   = 8 * FRAME_PE_BYTES;
  localparam int         CNT_BITS  = 3;
endpackage

// File: rtl/spi_erase_shifter.sv
module spi_erase_shifter
  import spi_erase_pkg::*;
#(
  parameter int PAGE_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_i,
  input  logic                 cs_n_i,
  input  logic                 mosi_i,
  output logic                 cs_active,
  output logic                 sclk_fall,
  output logic                 cs_rise,
  output logic [7:0]           first_byte,
  output logic [7:0]           last_byte,
  output logic [PAGE_BITS-1:0] page_field,
  output logic [CNT_BITS-1:0]  bit_idx,
  output logic [CNT_BITS-1:0]  byte_cnt
);
  localparam logic [CNT_BITS-1:0] BC_MAX = '1;

  logic sclk_s, sclk_d, cs_s, cs_d, mosi_s;
  logic sclk_rise;
  logic [SR_BITS-1:0]  sr_q, sr_n;
  logic [CNT_BITS-1:0] idx_q, idx_n, bc_q, bc_n;

  assign sclk_rise  = sclk_s & ~sclk_d & ~cs_s;
  assign sclk_fall  = ~sclk_s & sclk_d & ~cs_s;
  assign cs_rise    = cs_s & ~cs_d;
  assign cs_active  = ~cs_s;
  assign first_byte = sr_q[SR_BITS-1 -: 8];
  assign last_byte  = sr_q[7:0];
  assign page_field = sr_q[8 +: PAGE_BITS];
  assign bit_idx    = idx_q;
  assign byte_cnt   = bc_q;

  always_comb begin
    sr_n  = sr_q;
    idx_n = idx_q;
    bc_n  = bc_q;
    if (cs_s) begin
      idx_n = '0;
      bc_n  = '0;
    end else if (sclk_rise) begin
      sr_n  = {sr_q[SR_BITS-2:0], mosi_s};
      idx_n = idx_q + 1'b1;
      if (idx_q == 3'd7 && bc_q != BC_MAX) bc_n = bc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= 1'b0;
      sclk_d <= 1'b0;
      cs_s   <= 1'b1;
      cs_d   <= 1'b1;
      mosi_s <= 1'b0;
      sr_q   <= '0;
      idx_q  <= '0;
      bc_q   <= '0;
    end else begin
      sclk_s <= sclk_i;
      sclk_d <= sclk_s;
      cs_s   <= cs_n_i;
      cs_d   <= cs_s;
      mosi_s <= mosi_i;
      sr_q   <= sr_n;
      idx_q  <= idx_n;
      bc_q   <= bc_n;
    end
  end
endmodule

// File: rtl/spi_erase_ctrl.sv
module spi_erase_ctrl
  import spi_erase_pkg::*;
#(
  parameter int PAGE_BITS      = 9,
  parameter int WEL_CLR_CYCLES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_rise,
  input  logic [7:0]              first_byte,
  input  logic [7:0]              last_byte,
  input  logic [PAGE_BITS-1:0]    page_field,
  input  logic [CNT_BITS-1:0]     bit_idx,
  input  logic [CNT_BITS-1:0]     byte_cnt,
  input  logic [(1<<PAGE_BITS)-1:0] protect,
  input  logic                    erase_done,
  output logic                    wip,
  output logic                    wel,
  output logic [PAGE_BITS-1:0]    erase_page
);
  localparam int CW = $clog2(WEL_CLR_CYCLES + 1);
  localparam logic [CW-1:0] CLR_AT = CW'(WEL_CLR_CYCLES - 1);

  logic busy_q, busy_n, wel_q, wel_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [PAGE_BITS-1:0] page_q, page_n;
  logic frame_one, frame_pe, wren_ok, pe_ok;

  assign frame_one = (byte_cnt == 3'd1) && (bit_idx == 3'd0);
  assign frame_pe  = (byte_cnt == CNT_BITS'(FRAME_PE_BYTES)) && (bit_idx == 3'd0);
  assign wren_ok   = cs_rise & frame_one & (last_byte == OP_WREN) & ~busy_q;
  assign pe_ok     = cs_rise & frame_pe & (first_byte == OP_PERASE) & wel_q
                     & ~busy_q & ~protect[page_field];

  always_comb begin
    busy_n = busy_q;
    wel_n  = wel_q;
    cnt_n  = cnt_q;
    page_n = page_q;
    if (busy_q) begin
      if (cnt_q != CLR_AT) cnt_n = cnt_q + 1'b1;
      else                 wel_n = 1'b0;
      if (erase_done) begin
        busy_n = 1'b0;
        wel_n  = 1'b0;
      end
    end else begin
      if (wren_ok) wel_n = 1'b1;
      if (pe_ok) begin
        busy_n = 1'b1;
        cnt_n  = '0;
        page_n = page_field;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      cnt_q  <= '0;
      page_q <= '0;
    end else begin
      busy_q <= busy_n;
      wel_q  <= wel_n;
      cnt_q  <= cnt_n;
      page_q <= page_n;
    end
  end

  assign wip        = busy_q;
  assign wel        = wel_q;
  assign erase_page = page_q;
endmodule

// File: rtl/spi_erase_status_tx.sv
module spi_erase_status_tx
  import spi_erase_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_active,
  input  logic                sclk_fall,
  input  logic [CNT_BITS-1:0] bit_idx,
  input  logic [CNT_BITS-1:0] byte_cnt,
  input  logic [7:0]          last_byte,
  input  logic [7:0]          status,
  output logic                miso
);
  logic       rd_q, rd_n;
  logic [7:0] sh_q, sh_n;
  logic       at_byte, want_load;

  assign at_byte   = (bit_idx == 3'd0) && (byte_cnt != 3'd0);
  assign want_load = (byte_cnt == 3'd1) ? (last_byte == OP_RDSR) : rd_q;

  always_comb begin
    rd_n = rd_q;
    sh_n = sh_q;
    if (!cs_active) begin
      rd_n = 1'b0;
      sh_n = '0;
    end else if (sclk_fall) begin
      if (at_byte && want_load) begin
        rd_n = 1'b1;
        sh_n = status;
      end else if (rd_q) begin
        sh_n = {sh_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      sh_q <= '0;
    end else begin
      rd_q <= rd_n;
      sh_q <= sh_n;
    end
  end

  assign miso = sh_q[7];
endmodule

// File: rtl/spi_erase_frontend.sv
module spi_erase_frontend
  import spi_erase_pkg::*;
#(
  parameter int PAGE_BITS      = 9,
  parameter int WEL_CLR_CYCLES = 16,
  localparam int PAGES         = 1 << PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sclk,
  input  logic                 spi_cs_n,
  input  logic                 spi_mosi,
  output logic                 spi_miso,
  input  logic [PAGES-1:0]     page_protect,
  output logic                 erase_req,
  output logic [PAGE_BITS-1:0] erase_page,
  input  logic                 erase_done
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       cs_active, sclk_fall, cs_rise;
  logic [7:0] first_byte, last_byte, status_byte;
  logic [PAGE_BITS-1:0] page_field;
  logic [CNT_BITS-1:0]  bit_idx, byte_cnt;
  logic       wip_w, wel_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  spi_erase_shifter #(.PAGE_BITS(PAGE_BITS)) u_shift (
    .clk(clk), .rst_n(rst_int_n),
    .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .cs_active(cs_active), .sclk_fall(sclk_fall), .cs_rise(cs_rise),
    .first_byte(first_byte), .last_byte(last_byte), .page_field(page_field),
    .bit_idx(bit_idx), .byte_cnt(byte_cnt)
  );

  spi_erase_ctrl #(.PAGE_BITS(PAGE_BITS), .WEL_CLR_CYCLES(WEL_CLR_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .cs_rise(cs_rise),
    .first_byte(first_byte), .last_byte(last_byte), .page_field(page_field),
    .bit_idx(bit_idx), .byte_cnt(byte_cnt), .protect(page_protect),
    .erase_done(erase_done), .wip(wip_w), .wel(wel_w), .erase_page(erase_page)
  );

  always_comb begin
    status_byte         = '0;
    status_byte[ST_WIP] = wip_w;
    status_byte[ST_WEL] = wel_w;
  end

  spi_erase_status_tx u_stat (
    .clk(clk), .rst_n(rst_int_n), .cs_active(cs_active), .sclk_fall(sclk_fall),
    .bit_idx(bit_idx), .byte_cnt(byte_cnt), .last_byte(last_byte),
    .status(status_byte), .miso(spi_miso)
  );

  assign erase_req = wip_w;
endmodule

// File: rtl/spi_erase_frontend_chk.sv
module spi_erase_frontend_chk #(
  parameter int PAGE_BITS      = 9,
  parameter int WEL_CLR_CYCLES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 wel,
  input logic                 erase_done,
  input logic [PAGE_BITS-1:0] erase_page
);
  localparam int KW = $clog2(WEL_CLR_CYCLES + 3) + 1;
  localparam logic [KW-1:0] K_MAX = KW'(WEL_CLR_CYCLES + 2);

  logic [KW-1:0] busy_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      busy_cycles <= '0;
    else if (!busy)                  busy_cycles <= '0;
    else if (busy_cycles != K_MAX)   busy_cycles <= busy_cycles + 1'b1;
  end

  // R6
  wel_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  // R8
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(erase_done));

  // R9
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_cycles > KW'(WEL_CLR_CYCLES)) |-> !wel);

  // R10
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(erase_page));

  // R10
  wel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(busy));
endmodule

bind spi_erase_frontend spi_erase_frontend_chk #(
  .PAGE_BITS(PAGE_BITS), .WEL_CLR_CYCLES(WEL_CLR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(wip_w), .wel(wel_w),
  .erase_done(erase_done), .erase_page(erase_page)
);

// File: tb/spi_erase_frontend_bench.sv
module spi_erase_frontend_bench;
  localparam int PAGE_BITS = 9;
  localparam int PAGES     = 1 << PAGE_BITS;
  localparam int HALF      = 6;
  localparam int ERASE_LAT = 1200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
  logic [PAGES-1:0] prot = '0;
  logic erase_req, erase_done = 1'b0;
  logic [PAGE_BITS-1:0] erase_page;

  int checks = 0, errors = 0, req_count = 0;
  logic [PAGE_BITS-1:0] last_page = '0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_erase_frontend #(.PAGE_BITS(PAGE_BITS), .WEL_CLR_CYCLES(16)) u_spi_erase_frontend (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .page_protect(prot), .erase_req(erase_req),
    .erase_page(erase_page), .erase_done(erase_done)
  );

  // array model: answers each request after a fixed latency
  initial begin
    forever begin
      @(negedge clk);
      if (erase_req === 1'b1) begin
        req_count++;
        last_page = erase_page;
        repeat (ERASE_LAT) @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
      end
    end
  end

  function automatic logic [7:0] exp_status(input logic wip, input logic wel);
    return {6'b0, wel, wip};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_frame(input logic [39:0] tx, input int nbits, output logic [39:0] rx);
    rx = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[39-i];
      repeat (HALF) @(negedge clk);
      rx = {rx[38:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send(input logic [39:0] tx, input int nbits);
    logic [39:0] rx;
    spi_frame(tx, nbits, rx);
  endtask

  task automatic read_status(output logic [7:0] st);
    logic [39:0] rx;
    spi_frame({8'h05, 32'h0}, 16, rx);
    st = rx[7:0];
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 5000 && erase_req !== 1'b0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [39:0] pe_word(input logic [23:0] addr);
    return {8'hDB, addr, 8'h00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  st;
    logic [39:0] rx;
    int          n0;
    logic        wel_m;
    void'($urandom(32'd2718));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1
    chk(erase_req == 1'b0, "R1 req", {39'b0, erase_req}, 40'h0);
    chk(miso == 1'b0, "R1 miso", {39'b0, miso}, 40'h0);
    read_status(st);
    chk(st == 8'h00, "R1 status", {32'b0, st}, 40'h0);

    // R2: wrong lengths then exact
    send({8'h06, 32'h0}, 7);
    read_status(st);
    chk(st == exp_status(0, 0), "R2 7 bits", {32'b0, st}, 40'h0);
    send({8'h06, 32'h0}, 9);
    read_status(st);
    chk(st == exp_status(0, 0), "R2 9 bits", {32'b0, st}, 40'h0);
    send({8'h06, 32'h0}, 8);
    read_status(st);
    chk(st == exp_status(0, 1), "R2 wren", {32'b0, st}, 40'h2);

    // R3: repeated status byte, zero during opcode
    spi_frame({8'h05, 32'h0}, 24, rx);
    chk(rx[23:0] == {8'h00, 8'h02, 8'h02}, "R3 repeat", rx, 40'h0202);

    // R5: wrong erase lengths
    n0 = req_count;
    send(pe_word(24'h01_2300), 31);
    repeat (4) @(negedge clk);
    chk(req_count == n0, "R5 31 bits", 40'(req_count), 40'(n0));
    send(pe_word(24'h01_2300), 33);
    repeat (4) @(negedge clk);
    chk(req_count == n0, "R5 33 bits", 40'(req_count), 40'(n0));
    read_status(st);
    chk(st == exp_status(0, 1), "R5 wel kept", {32'b0, st}, 40'h2);

    // R7: protected page
    prot[9'h055] = 1'b1;
    send(pe_word(24'h00_5577), 32);
    repeat (4) @(negedge clk);
    chk(req_count == n0, "R7 protected", 40'(req_count), 40'(n0));
    read_status(st);
    chk(st == exp_status(0, 1), "R7 wel kept", {32'b0, st}, 40'h2);
    prot = '0;

    // R4: accepted erase, high address bits ignored
    send(pe_word(24'hFF_2C_11), 32);
    repeat (4) @(negedge clk);
    chk(req_count == n0 + 1, "R4 request", 40'(req_count), 40'(n0 + 1));
    chk(last_page == 9'h12C, "R4 page", 40'(last_page), 40'h12C);
    chk(erase_req == 1'b1, "R8 req held", {39'b0, erase_req}, 40'h1);
    // R10: commands while busy
    send({8'h06, 32'h0}, 8);
    send(pe_word(24'h00_0100), 32);
    repeat (4) @(negedge clk);
    chk(req_count == n0 + 1, "R10 no new req", 40'(req_count), 40'(n0 + 1));
    chk(erase_page == 9'h12C && erase_req == 1'b1, "R10 page held", 40'(erase_page), 40'h12C);
    read_status(st);
    chk(st == exp_status(1, 0), "R8 R9 busy status", {32'b0, st}, 40'h1);
    wait_idle();
    read_status(st);
    chk(st == exp_status(0, 0), "R8 R10 after done", {32'b0, st}, 40'h0);

    // R6: no latch
    n0 = req_count;
    send(pe_word(24'h00_4400), 32);
    repeat (4) @(negedge clk);
    chk(req_count == n0, "R6 no wel", 40'(req_count), 40'(n0));

    // random trials
    wel_m = 1'b0;
    for (int t = 0; t < 12; t++) begin
      logic [PAGE_BITS-1:0] pg;
      logic [23:0] addr;
      int nb;
      bit exec;
      pg   = PAGE_BITS'($urandom);
      addr = {7'($urandom), pg, 8'($urandom)};
      prot = '0;
      prot[pg] = ($urandom % 4) == 0;
      case ($urandom % 4)
        0: nb = 31;
        1: nb = 33;
        default: nb = 32;
      endcase
      if (($urandom % 4) != 0) begin
        send({8'h06, 32'h0}, 8);
        wel_m = 1'b1;
      end
      n0 = req_count;
      exec = (nb == 32) && wel_m && !prot[pg];
      send(pe_word(addr), nb);
      repeat (4) @(negedge clk);
      chk(req_count == n0 + (exec ? 1 : 0), "R4 R5 R6 R7 random req",
          40'(req_count), 40'(n0 + (exec ? 1 : 0)));
      if (exec) begin
        chk(last_page == pg, "R4 random page", 40'(last_page), 40'(pg));
        wel_m = 1'b0;
      end
      wait_idle();
      read_status(st);
      chk(st == exp_status(0, wel_m), "R9 random status", {32'b0, st}, {32'b0, exp_status(0, wel_m)});
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule